// File: doc/BRIEF.md
# Event-Triggered Delayed Pulse Generator

This block belongs to a timing receiver. The decoded link delivers an 8-bit event code together with a one-cycle valid strobe. The block looks the code up in a 256-row response table. Each row picks one of sixteen shared timing profiles, or the per-output default registers. It also selects pulse or toggle behaviour, chooses which of four auxiliary outputs respond, and says whether the event raises an interrupt strobe.

Each auxiliary output is driven by its own channel, so all four respond at the same time and do not affect one another. A profile holds a delay and a width for every output. Both values are counted in ticks of the receiver clock. In pulse mode an output goes high once its delay has elapsed and stays high for its width. In toggle mode the output inverts once its delay has elapsed. A host loads the tables and default registers through a simple single-cycle write port.

Top module: `evt_pulse_gen`

## Requirements
- R1: After reset all four outputs, the interrupt strobe and the last-event register read zero, and every response row is cleared.
- R2: The cycle after an event whose row has its interrupt bit (row bit 5) set, `irq_pulse` is high for exactly one cycle. It stays low for events whose row has that bit clear.
- R3: `last_evt` shows the code of the most recent event from the cycle after it is sampled, and holds that value until the next event.
- R4: In pulse mode (row bit 4 = 0), an enabled output with delay D and width W goes high exactly D+2 cycles after the edge that samples the event, and stays high for exactly W cycles.
- R5: In toggle mode (row bit 4 = 1), an enabled output inverts its level exactly D+2 cycles after the sampling edge and keeps the new level.
- R6: Only outputs whose bit is set in the row's output mask (row bits 9:6, bit 6 for output 0) respond. The other outputs keep their level.
- R7: A pulse-mode event that meets a width of zero has no effect on that output.
- R8: Row bits 3:0 select the profile that supplies delay and width. When row bit 10 is set, each enabled output uses its default register instead.
- R9: An event that reaches an output whose response is still pending restarts that output's delay from the new event. The output keeps its current level until the new delay expires.
- R10: Outputs enabled by the same event run concurrently, each with its own delay and width from the selected profile.
- R11: Host writes are decoded by address bits 9:8. Region 0 writes the response row at the index in bits 7:0. Region 1 writes profile bits 5:2 for output bits 1:0, with the delay in data bits 15:0 and the width in data bits 31:16. Region 2 writes the default register of output bits 1:0, using the same data layout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock; delays and widths count its ticks |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Host write strobe |
| cfg_addr | input | 10 | Host write address: region in bits 9:8, index below |
| cfg_wdata | input | 32 | Host write data |
| evt_valid | input | 1 | Event code strobe |
| evt_code | input | 8 | Event code |
| aux_out | output | 4 | Auxiliary trigger outputs |
| irq_pulse | output | 1 | One-cycle interrupt strobe |
| last_evt | output | 8 | Code of the most recent event |

## Verification
The bench samples every output in every cycle of each response window. An off-by-one error in the delay or width load therefore shows up as an early or late edge, or as a pulse one cycle too long or too short.

A second event is sent while the first is still pending. An output that ignored the restart would fire at the first event's time, and the bench checks for that. A zero-width pulse event is sent, and a design that loaded W-1 would wrap the width and hold the output high for a very long time. Toggle events are sent twice to show the level inverting back. Finally, the default-register path uses a profile pointer whose profile holds a different delay, so a design that ignored the select bit would fire at the wrong time.

// File: rtl/evp_pkg.sv
package evp_pkg;

   // host write regions, decoded from the two top address bits
   typedef enum logic [1:0] {
      RGN_ROW  = 2'd0,
      RGN_PROF = 2'd1,
      RGN_DFLT = 2'd2,
      RGN_NONE = 2'd3
   } cfg_region_e;

   typedef enum logic [1:0] {
      CH_IDLE = 2'd0,
      CH_WAIT = 2'd1,
      CH_HIGH = 2'd2
   } ch_state_e;

endpackage

// File: rtl/evp_resp_table.sv
module evp_resp_table #(
   parameter int CODE_W = 8,
   parameter int ROW_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_idx,
   input  logic [ROW_W-1:0]  wr_row,
   input  logic              evt_valid,
   input  logic [CODE_W-1:0] evt_code,
   output logic              hit_q,
   output logic [ROW_W-1:0]  row_q,
   output logic [CODE_W-1:0] code_q
);
   localparam int DEPTH = 2 ** CODE_W;

   logic [ROW_W-1:0] rows [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < DEPTH; r++) rows[r] <= '0;
      end else if (wr_en) begin
         rows[wr_idx] <= wr_row;
      end
   end

   // lookup stage: row and code captured on the sampling edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q  <= 1'b0;
         row_q  <= '0;
         code_q <= '0;
      end else begin
         hit_q <= evt_valid;
         if (evt_valid) begin
            row_q  <= rows[evt_code];
            code_q <= evt_code;
         end
      end
   end
endmodule

// File: rtl/evp_profile_store.sv
module evp_profile_store #(
   parameter int NUM_OUT = 4,
   parameter int PROF_N  = 16,
   parameter int TIME_W  = 16,
   localparam int PTR_W  = $clog2(PROF_N),
   localparam int OSEL_W = $clog2(NUM_OUT)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            prof_we,
   input  logic                            dflt_we,
   input  logic [PTR_W-1:0]                wr_prof,
   input  logic [OSEL_W-1:0]               wr_out,
   input  logic [2*TIME_W-1:0]             wr_data,
   input  logic [PTR_W-1:0]                sel_prof,
   input  logic                            use_dflt,
   output logic [NUM_OUT-1:0][TIME_W-1:0]  dly_o,
   output logic [NUM_OUT-1:0][TIME_W-1:0]  wid_o
);
   // each entry: {width, delay}
   logic [2*TIME_W-1:0] prof [PROF_N][NUM_OUT];
   logic [2*TIME_W-1:0] dflt [NUM_OUT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < PROF_N; p++)
            for (int o = 0; o < NUM_OUT; o++) prof[p][o] <= '0;
         for (int o = 0; o < NUM_OUT; o++) dflt[o] <= '0;
      end else begin
         if (prof_we) prof[wr_prof][wr_out] <= wr_data;
         if (dflt_we) dflt[wr_out] <= wr_data;
      end
   end

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_rd
      logic [2*TIME_W-1:0] ent;
      always_comb begin
         ent = use_dflt ? dflt[o] : prof[sel_prof][o];
      end
      assign dly_o[o] = ent[TIME_W-1:0];
      assign wid_o[o] = ent[2*TIME_W-1:TIME_W];
   end
endmodule

// File: rtl/evp_channel.sv
module evp_channel
   import evp_pkg::*;
#(
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              toggle,
   input  logic [TIME_W-1:0] dly,
   input  logic [TIME_W-1:0] wid,
   output logic              busy,
   output logic              out
);
   ch_state_e         state;
   logic [TIME_W-1:0] cnt;
   logic [TIME_W-1:0] wid_q;
   logic              tgl_q;
   logic              accept;

   // a zero-width pulse request never arms the channel
   assign accept = start && (toggle || (wid != '0));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= CH_IDLE;
         cnt   <= '0;
         wid_q <= '0;
         tgl_q <= 1'b0;
         out   <= 1'b0;
      end else if (accept) begin
         state <= CH_WAIT;
         cnt   <= dly;
         wid_q <= wid;
         tgl_q <= toggle;
      end else begin
         unique case (state)
            CH_WAIT: begin
               if (cnt == '0) begin
                  if (tgl_q) begin
                     out   <= ~out;
                     state <= CH_IDLE;
                  end else begin
                     out   <= 1'b1;
                     cnt   <= wid_q - 1'b1;
                     state <= CH_HIGH;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            CH_HIGH: begin
               if (cnt == '0) begin
                  out   <= 1'b0;
                  state <= CH_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: state <= CH_IDLE;
         endcase
      end
   end

   assign busy = (state != CH_IDLE);
endmodule

// File: rtl/evt_pulse_gen.sv
module evt_pulse_gen
   import evp_pkg::*;
#(
   parameter int NUM_OUT = 4,
   parameter int CODE_W  = 8,
   parameter int PROF_N  = 16,
   parameter int TIME_W  = 16,
   parameter int ADDR_W  = 10,
   parameter int CFG_W   = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [CFG_W-1:0]   cfg_wdata,
   input  logic               evt_valid,
   input  logic [CODE_W-1:0]  evt_code,
   output logic [NUM_OUT-1:0] aux_out,
   output logic               irq_pulse,
   output logic [CODE_W-1:0]  last_evt
);
   localparam int PTR_W   = $clog2(PROF_N);
   localparam int OSEL_W  = $clog2(NUM_OUT);
   localparam int IDX_W   = ADDR_W - 2;
   // response row layout
   localparam int F_PTR   = 0;
   localparam int F_TGL   = PTR_W;
   localparam int F_IRQ   = PTR_W + 1;
   localparam int F_MASK  = PTR_W + 2;
   localparam int F_DFLT  = PTR_W + 2 + NUM_OUT;
   localparam int ROW_W   = F_DFLT + 1;

   if (PROF_N != 2 ** PTR_W) begin : g_chk_prof
      $error("PROF_N must be a power of two");
   end
   if (IDX_W < CODE_W || IDX_W < PTR_W + OSEL_W) begin : g_chk_addr
      $error("ADDR_W too narrow for table index");
   end
   if (CFG_W < 2 * TIME_W || CFG_W < ROW_W) begin : g_chk_data
      $error("CFG_W too narrow for a table entry");
   end

   // host write decode
   cfg_region_e      region;
   logic [IDX_W-1:0] idx;
   logic             row_we, prof_we, dflt_we;

   assign region  = cfg_region_e'(cfg_addr[ADDR_W-1 -: 2]);
   assign idx     = cfg_addr[IDX_W-1:0];
   assign row_we  = cfg_we && (region == RGN_ROW);
   assign prof_we = cfg_we && (region == RGN_PROF);
   assign dflt_we = cfg_we && (region == RGN_DFLT);

   logic              hit_q;
   logic [ROW_W-1:0]  row_q;

   evp_resp_table #(
      .CODE_W (CODE_W),
      .ROW_W  (ROW_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (row_we),
      .wr_idx    (idx[CODE_W-1:0]),
      .wr_row    (cfg_wdata[ROW_W-1:0]),
      .evt_valid (evt_valid),
      .evt_code  (evt_code),
      .hit_q     (hit_q),
      .row_q     (row_q),
      .code_q    (last_evt)
   );

   logic [NUM_OUT-1:0][TIME_W-1:0] dly_v, wid_v;

   evp_profile_store #(
      .NUM_OUT (NUM_OUT),
      .PROF_N  (PROF_N),
      .TIME_W  (TIME_W)
   ) u_prof (
      .clk      (clk),
      .rst_n    (rst_n),
      .prof_we  (prof_we),
      .dflt_we  (dflt_we),
      .wr_prof  (idx[OSEL_W +: PTR_W]),
      .wr_out   (idx[OSEL_W-1:0]),
      .wr_data  (cfg_wdata[2*TIME_W-1:0]),
      .sel_prof (row_q[F_PTR +: PTR_W]),
      .use_dflt (row_q[F_DFLT]),
      .dly_o    (dly_v),
      .wid_o    (wid_v)
   );

   assign irq_pulse = hit_q & row_q[F_IRQ];

   logic [NUM_OUT-1:0] ch_busy;

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_ch
      evp_channel #(
         .TIME_W (TIME_W)
      ) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .start  (hit_q & row_q[F_MASK + o]),
         .toggle (row_q[F_TGL]),
         .dly    (dly_v[o]),
         .wid    (wid_v[o]),
         .busy   (ch_busy[o]),
         .out    (aux_out[o])
      );
   end
endmodule

// File: rtl/evp_checker.sv
module evp_checker #(
   parameter int NUM_OUT = 4,
   parameter int CODE_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               evt_valid,
   input logic [CODE_W-1:0]  evt_code,
   input logic               irq_pulse,
   input logic [CODE_W-1:0]  last_evt,
   input logic [NUM_OUT-1:0] aux_out,
   input logic [NUM_OUT-1:0] ch_busy
);
   // R2: a strobe only follows a sampled event
   a_r2_irq_after_event: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(evt_valid));

   a_r2_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |=> !irq_pulse);

   // R3: code captured then held
   a_r3_code_latched: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |=> (last_evt == $past(evt_code)));

   a_r3_code_held: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |=> $stable(last_evt));

   // R6: an output moves only out of an armed channel
   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      a_r6_move_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(aux_out[o]) |-> $past(ch_busy[o]));
   end
endmodule

bind evt_pulse_gen evp_checker #(
   .NUM_OUT (NUM_OUT),
   .CODE_W  (CODE_W)
) u_evp_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_valid (evt_valid),
   .evt_code  (evt_code),
   .irq_pulse (irq_pulse),
   .last_evt  (last_evt),
   .aux_out   (aux_out),
   .ch_busy   (ch_busy)
);

// File: tb/test_evt_pulse_gen.sv
module test_evt_pulse_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [9:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic       evt_valid = 1'b0;
   logic [7:0] evt_code = '0;
   logic [3:0] aux_out;
   logic       irq_pulse;
   logic [7:0] last_evt;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   evt_pulse_gen i_evt_pulse_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .evt_valid (evt_valid),
      .evt_code  (evt_code),
      .aux_out   (aux_out),
      .irq_pulse (irq_pulse),
      .last_evt  (last_evt)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // R11: region in addr[9:8]
   task automatic cfg_write(input logic [1:0] rgn, input logic [7:0] idx, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = {rgn, idx}; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic logic [31:0] mkrow(input int ptr, input bit tgl, input bit irq,
                                         input logic [3:0] mask, input bit dflt);
      return {21'd0, dflt, mask, irq, tgl, ptr[3:0]};
   endfunction

   task automatic set_prof(input int p, input int o, input int d, input int w);
      cfg_write(2'd1, {2'b00, p[3:0], o[1:0]}, {w[15:0], d[15:0]});
   endtask

   // returns just after the sampling edge
   task automatic send_evt(input logic [7:0] code);
      @(negedge clk);
      evt_valid = 1'b1; evt_code = code;
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   // pulse-mode window check, every output every cycle
   task automatic watch(input string req, input int d [4], input int w [4],
                        input logic [3:0] en, input int cycles);
      for (int k = 1; k <= cycles; k++) begin
         @(negedge clk);
         for (int i = 0; i < 4; i++) begin
            logic e;
            e = en[i] && (k >= d[i] + 2) && (k < d[i] + 2 + w[i]);
            check($sformatf("%s out%0d k=%0d", req, i, k), aux_out[i], e);
         end
         check($sformatf("R2 no strobe k=%0d", k), irq_pulse, 1'b0);
      end
   endtask

   task automatic t_reset;
      check("R1 aux_out reset", aux_out, 4'h0);
      check("R1 irq reset", irq_pulse, 1'b0);
      check("R1 last_evt reset", last_evt, 8'h00);
   endtask

   task automatic t_pulse;
      set_prof(3, 0, 5, 3);
      set_prof(3, 3, 1, 1);
      cfg_write(2'd0, 8'h21, mkrow(3, 0, 1, 4'b0001, 0));
      send_evt(8'h21);
      check("R2 strobe on irq row", irq_pulse, 1'b1);
      check("R3 code latched", last_evt, 8'h21);
      watch("R4 R6 pulse", '{5, 0, 0, 0}, '{3, 0, 0, 0}, 4'b0001, 14);
      check("R3 code held", last_evt, 8'h21);
   endtask

   task automatic t_concurrent;
      for (int i = 0; i < 4; i++) set_prof(5, i, 2 * (i + 1), 2);
      cfg_write(2'd0, 8'h40, mkrow(5, 0, 0, 4'b1111, 0));
      send_evt(8'h40);
      check("R2 no strobe without irq bit", irq_pulse, 1'b0);
      check("R3 code latched", last_evt, 8'h40);
      watch("R10 R8 concurrent", '{2, 4, 6, 8}, '{2, 2, 2, 2}, 4'b1111, 14);
   endtask

   task automatic t_toggle;
      cfg_write(2'd0, 8'h80, mkrow(5, 1, 0, 4'b0010, 0));
      for (int rep = 0; rep < 2; rep++) begin
         send_evt(8'h80);
         for (int k = 1; k <= 9; k++) begin
            logic e;
            @(negedge clk);
            e = (rep == 0) ? (k >= 6) : (k < 6);
            check($sformatf("R5 toggle rep%0d k=%0d", rep, k), aux_out[1], e);
            check($sformatf("R6 others k=%0d", k), {aux_out[3:2], aux_out[0]}, 3'b000);
         end
      end
   endtask

   task automatic t_zero_width;
      set_prof(7, 2, 1, 0);
      cfg_write(2'd0, 8'h07, mkrow(7, 0, 0, 4'b0100, 0));
      send_evt(8'h07);
      watch("R7 zero width", '{0, 0, 0, 0}, '{0, 0, 0, 0}, 4'b0000, 10);
   endtask

   task automatic t_default;
      cfg_write(2'd2, 8'h03, {16'd4, 16'd3});
      cfg_write(2'd0, 8'h99, mkrow(5, 0, 0, 4'b1000, 1));
      send_evt(8'h99);
      check("R3 code latched", last_evt, 8'h99);
      watch("R8 R11 default regs", '{0, 0, 0, 3}, '{0, 0, 0, 4}, 4'b1000, 14);
   endtask

   task automatic t_restart;
      send_evt(8'h21);
      @(negedge clk);
      @(negedge clk);
      send_evt(8'h21);
      check("R9 irq on second event", irq_pulse, 1'b1);
      watch("R9 restart", '{5, 0, 0, 0}, '{3, 0, 0, 0}, 4'b0001, 14);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_pulse;
      t_concurrent;
      t_toggle;
      t_zero_width;
      t_default;
      t_restart;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule